// File: doc/BRIEF.md
# Synchronous Burst SRAM

A synthesizable, single-clock behavioural model of a burst-capable static RAM with a small parameterised array. Every input except the output enable and the burst-order select is sampled on the rising clock edge. Two address strobes can open a new access: a processor-side strobe that only reads, and a controller-side strobe that can read or write. Once an access is open, an advance input steps a two-bit burst counter or holds it.

The counter changes only the two low address bits. It steps either linearly with wrap-around or in an interleaved order, chosen by a static select pin. Writes can cover a single byte lane or all lanes, and a global write overrides the per-lane controls. Read data reaches the pins one clock after the cycle that registered the address. The data pins float when the output enable is high, during write slots, and one cycle after a deselect.

The bidirectional data bus appears as three signals: an input bus, an output bus and an output-enable indication.

Top module: `burst_sram`

## Requirements
- R1: During and after reset, with no access started, `dout_en` is low.
- R2: A read cycle registered at rising edge N puts the addressed word on `dout` with `dout_en` high after edge N+1, provided `oe_n` is low.
- R3: `strb_p_n` low with `ce1_n` low takes priority over `strb_c_n`. If all enables are asserted it opens a read at `addr`, whatever `gw_n`, `we_n` and `bw_n` are.
- R4: `strb_p_n` low while `ce1_n` is high has no effect. The burst goes on as if both strobes were high.
- R5: An accepted strobe with any enable inactive deselects the device (`ce1_n` high, `ce2` low or `ce3_n` high). If `strb_p_n` opened the access, the deselect comes from `ce2` low or `ce3_n` high. `dout_en` is then low after the next edge, and later continue cycles do nothing (R13).
- R6: With `order_il`=0 the low two address bits of successive burst addresses are start+k mod 4. The upper bits do not change.
- R7: With `order_il`=1 the low two address bits are start XOR k, for k = 0,1,2,3.
- R8: With both strobes inactive and `adv_n` high, the burst address is held and the cycle repeats at the same address.
- R9: `gw_n` low in a write-capable cycle writes every lane, whatever `we_n` and `bw_n` are.
- R10: With `gw_n` high, lane i (bits i*LANE_W upward) is written only when `we_n` and `bw_n[i]` are both low. If `we_n` is high or no lane is selected, the cycle is a read.
- R11: Write data on `din` is taken on the same edge as the write controls and stored at that cycle's burst address. A write slot leaves `dout_en` low.
- R12: `oe_n` high forces `dout_en` low at once, without waiting for a clock.
- R13: A continue cycle while deselected neither reads nor writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address, taken when a strobe is accepted |
| ce1_n | input | 1 | Primary enable, active low; also gates `strb_p_n` |
| ce2 | input | 1 | Expansion enable, active high |
| ce3_n | input | 1 | Expansion enable, active low |
| strb_p_n | input | 1 | Processor address strobe, read only, active low |
| strb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| gw_n | input | 1 | Global write, active low |
| we_n | input | 1 | Lane write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | High while the data pins are driven |

## Verification
The embedded properties run on every cycle. They cover strobe priority into a read, the deselect timing, freezing of the counter on suspend, a step of exactly one on advance, and the idle behaviour of continue cycles after a deselect. Data integrity cannot be seen in a single-cycle property. The bench's reference model has to show the linear and interleaved address sequences, every lane-select combination and the global-write override against its own array. The same applies to read-before-write ordering across back-to-back cycles and the asynchronous float when `oe_n` rises.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     ce1_n,
  input  logic                     ce2,
  input  logic                     ce3_n,
  input  logic                     strb_p_n,
  input  logic                     strb_c_n,
  input  logic                     adv_n,
  input  logic                     order_il,
  input  logic                     gw_n,
  input  logic                     we_n,
  input  logic [LANES-1:0]         bw_n,
  input  logic                     oe_n,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dout_en
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic              act;
  logic [ADDR_W-1:0] base;
  logic [1:0]        k;
  logic              s1_rd;
  logic [ADDR_W-1:0] s1_addr;
  logic              q_vld;
  logic [DW-1:0]     q_data;

  logic              ld_p, ld_c, load, sel_ok;
  logic [LANES-1:0]  lane_we;
  logic              wr_any;
  logic              nxt_act;
  logic [ADDR_W-1:0] nxt_base;
  logic [1:0]        nxt_k, lo;
  logic              cyc_go, cyc_wr, cyc_rd;
  logic [ADDR_W-1:0] cyc_addr;

  assign ld_p    = !strb_p_n && !ce1_n;
  assign ld_c    = !ld_p && !strb_c_n;
  assign load    = ld_p || ld_c;
  assign sel_ok  = !ce1_n && ce2 && !ce3_n;
  assign lane_we = gw_n ? (we_n ? '0 : ~bw_n) : '1;
  assign wr_any  = |lane_we;

  assign nxt_act  = load ? sel_ok : act;
  assign nxt_base = load ? addr : base;
  assign nxt_k    = load ? 2'd0 : ((act && !adv_n) ? k + 2'd1 : k);
  assign lo       = order_il ? (nxt_base[1:0] ^ nxt_k) : (nxt_base[1:0] + nxt_k);
  assign cyc_addr = {nxt_base[ADDR_W-1:2], lo};
  assign cyc_go   = nxt_act;
  assign cyc_wr   = cyc_go && wr_any && !ld_p;
  assign cyc_rd   = cyc_go && !cyc_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      base    <= '0;
      k       <= 2'd0;
      s1_rd   <= 1'b0;
      s1_addr <= '0;
      q_vld   <= 1'b0;
      q_data  <= '0;
    end else begin
      act     <= nxt_act;
      base    <= nxt_base;
      k       <= nxt_k;
      s1_rd   <= cyc_rd;
      s1_addr <= cyc_addr;
      q_vld   <= s1_rd;
      q_data  <= mem[s1_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (cyc_wr) begin
      for (int l = 0; l < LANES; l++)
        if (lane_we[l]) mem[cyc_addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
    end
  end

  assign dout    = q_data;
  assign dout_en = q_vld && !oe_n;

  AST_DESEL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strb_c_n || (!strb_p_n && !ce1_n)) && (ce1_n || !ce2 || ce3_n)) |=> ##1 !q_vld); // R5
  AST_PROC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_p_n && !ce1_n && ce2 && !ce3_n) |=> s1_rd); // R3
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_c_n && (strb_p_n || ce1_n) && adv_n) |=> ($stable(k) && $stable(base))); // R8
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_c_n && (strb_p_n || ce1_n) && !adv_n && act) |=> (k == $past(k) + 2'd1)); // R6
  AST_IDLE_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_c_n && (strb_p_n || ce1_n) && !act) |=> !s1_rd); // R13
endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int AW = 6, NL = 2, LW = 9, DW = NL * LW, DEP = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic strb_p_n = 1'b1, strb_c_n = 1'b1, adv_n = 1'b1, order_il = 1'b0;
  logic gw_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
    .clk, .rst_n, .addr, .ce1_n, .ce2, .ce3_n, .strb_p_n, .strb_c_n, .adv_n,
    .order_il, .gw_n, .we_n, .bw_n, .oe_n, .din, .dout, .dout_en);

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  string req = "R1";

  logic [DW-1:0] mm [DEP];
  bit m_act = 0;
  int m_base = 0, m_k = 0;
  bit p1v = 0, p2v = 0;
  int p1a = 0;
  logic [DW-1:0] p2d = '0;

  task automatic check(input string r, input logic [DW-1:0] act_v, input logic [DW-1:0] exp_v);
    tests++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act_v, exp_v);
    end
  endtask

  task automatic model();
    bit lp, lc, ok, go, wr;
    bit [NL-1:0] lw;
    int a;
    p2v = p1v;
    p2d = mm[p1a];
    lp = !strb_p_n && !ce1_n;
    lc = !lp && !strb_c_n;
    ok = !ce1_n && ce2 && !ce3_n;
    for (int l = 0; l < NL; l++) lw[l] = !gw_n || (!we_n && !bw_n[l]);
    go = 0; wr = 0;
    if (lp || lc) begin
      m_act = ok; m_base = addr; m_k = 0;
      go = ok; wr = lc && (lw != 0);
    end else if (m_act) begin
      if (!adv_n) m_k = (m_k + 1) % 4;
      go = 1; wr = (lw != 0);
    end
    a = (m_base & ~3) | (order_il ? ((m_base & 3) ^ m_k) : (((m_base & 3) + m_k) % 4));
    p1v = go && !wr;
    p1a = a;
    if (go && wr)
      for (int l = 0; l < NL; l++) if (lw[l]) mm[a][l*LW +: LW] = din[l*LW +: LW];
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model();
    @(negedge clk);
    check({req, " dout_en"}, {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, p2v && !oe_n});
    if (p2v && !oe_n) check({req, " dout"}, dout, p2d);
  endtask

  task automatic idle();
    strb_p_n = 1; strb_c_n = 1; adv_n = 1; gw_n = 1; we_n = 1; bw_n = '1;
  endtask

  task automatic ctrl(input int a, input bit g, input bit w, input logic [NL-1:0] b, input logic [DW-1:0] d);
    idle(); strb_c_n = 0; addr = a[AW-1:0]; gw_n = g; we_n = w; bw_n = b; din = d; tick();
  endtask

  task automatic cont(input bit adv, input bit g, input bit w, input logic [NL-1:0] b, input logic [DW-1:0] d);
    idle(); adv_n = adv; gw_n = g; we_n = w; bw_n = b; din = d; tick();
  endtask

  initial begin
    #(4 * 50000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEP; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    req = "R1";
    check("R1 reset", {{(DW-1){1'b0}}, dout_en}, '0);
    rst_n = 1;
    tick(); tick();

    req = "R9";
    ctrl(4, 0, 1, '1, 18'h10a01);
    req = "R11";
    for (int i = 1; i < 4; i++) cont(0, 0, 1, '1, 18'h10a00 + DW'(i));
    cont(1, 1, 1, '1, '0); cont(1, 1, 1, '1, '0);

    req = "R6";
    ctrl(5, 1, 1, '1, '0);
    for (int i = 0; i < 3; i++) cont(0, 1, 1, '1, '0);
    cont(1, 1, 1, '1, '0); cont(1, 1, 1, '1, '0);

    req = "R7";
    order_il = 1;
    ctrl(6, 1, 1, '1, '0);
    for (int i = 0; i < 3; i++) cont(0, 1, 1, '1, '0);
    ctrl(13, 0, 0, '0, 18'h2bead);
    for (int i = 0; i < 3; i++) cont(0, 0, 1, '1, 18'h31000 + DW'(i));
    ctrl(13, 1, 1, '1, '0);
    for (int i = 0; i < 3; i++) cont(0, 1, 1, '1, '0);
    order_il = 0;

    req = "R8";
    ctrl(8, 1, 1, '1, '0);
    cont(1, 1, 1, '1, '0); cont(1, 1, 1, '1, '0);
    cont(0, 1, 1, '1, '0); cont(1, 1, 1, '1, '0);

    req = "R10";
    ctrl(20, 1, 0, 2'b10, 18'h155aa);
    cont(0, 1, 0, 2'b01, 18'h0aa55);
    cont(0, 1, 0, 2'b00, 18'h3ffff);
    cont(0, 1, 0, 2'b11, 18'h12345);
    cont(1, 1, 1, 2'b00, 18'h11111);
    ctrl(20, 1, 1, '1, '0);
    for (int i = 0; i < 3; i++) cont(0, 1, 1, '1, '0);
    cont(1, 1, 1, '1, '0);

    req = "R3";
    idle(); strb_p_n = 0; strb_c_n = 0; addr = 4; gw_n = 0; we_n = 0; bw_n = '0; din = 18'h3c3c3; tick();
    cont(0, 0, 0, '0, 18'h0f0f0);
    cont(1, 1, 1, '1, '0);
    ctrl(4, 1, 1, '1, '0);
    cont(0, 1, 1, '1, '0); cont(1, 1, 1, '1, '0);

    req = "R4";
    ctrl(8, 1, 1, '1, '0);
    ce1_n = 1; idle(); strb_p_n = 0; addr = 40; adv_n = 0; tick();
    idle(); strb_p_n = 0; addr = 41; adv_n = 0; tick();
    ce1_n = 0; cont(1, 1, 1, '1, '0); cont(1, 1, 1, '1, '0);

    req = "R5";
    ctrl(5, 1, 1, '1, '0);
    ce1_n = 1; ctrl(5, 1, 1, '1, '0); ce1_n = 0;
    req = "R13";
    cont(0, 1, 1, '1, '0); cont(0, 0, 0, '0, 18'h1dead); cont(1, 1, 1, '1, '0);
    req = "R5";
    ctrl(5, 1, 1, '1, '0);
    ce2 = 0; ctrl(5, 1, 1, '1, '0); ce2 = 1;
    cont(0, 1, 1, '1, '0);
    ctrl(5, 1, 1, '1, '0);
    ce3_n = 1; ctrl(5, 1, 1, '1, '0); ce3_n = 0;
    cont(0, 1, 1, '1, '0);
    ctrl(5, 1, 1, '1, '0);
    ce2 = 0; idle(); strb_p_n = 0; addr = 5; tick(); ce2 = 1;
    cont(0, 1, 1, '1, '0);
    ce3_n = 1; idle(); strb_p_n = 0; addr = 6; tick(); ce3_n = 0;
    cont(1, 1, 1, '1, '0);
    req = "R13";
    ctrl(4, 1, 1, '1, 18'h0);
    cont(0, 1, 1, '1, '0); cont(0, 1, 1, '1, '0); cont(1, 1, 1, '1, '0);

    req = "R12";
    ctrl(20, 1, 1, '1, '0);
    cont(0, 1, 1, '1, '0);
    oe_n = 1; #1;
    check("R12 float", {{(DW-1){1'b0}}, dout_en}, '0);
    cont(0, 1, 1, '1, '0);
    oe_n = 0; #1;
    check("R12 drive", {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, 1'b1});
    req = "R2";
    cont(0, 1, 1, '1, '0); cont(1, 1, 1, '1, '0); cont(1, 1, 1, '1, '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule